// File: doc/BRIEF.md
# Memory Address-Decoder Fault Test Engine

This block is a self-test sequencer aimed at the address decoding of a memory organised as rows of columns, not at its storage cells. It owns a plain synchronous port to the memory under test: one write or one read per cycle, addressed by a row and a column, with read data arriving one cycle after the read request. The memory itself sits outside the block.

A run begins on a start pulse. The engine zeroes every entry, then walks the array with rows ascending. At each entry it reads the entry, waits for the data and checks that it is still zero. It then writes all ones. A second zeroing and walk follow, this time with rows descending. Columns ascend within a row in both walks. If an entry reads nonzero, some earlier write must have landed on it through a decoder fault. The engine records that entry as the victim, zeroes the array again and repeats the same walk. Before each write in this repeat it reads the victim again. The first write after which the victim turns nonzero is reported as the aggressor. The run then stops.

Locations are reported as packed codes: the row shifted left by three, with the column in the low three bits.

Top module: `mdft_engine`

## Requirements
- R1: After reset, busy, done and fail are low, both code outputs are zero, and neither mem_we nor mem_re is asserted.
- R2: A start pulse while busy is high has no effect. The run in progress keeps its length and its result.
- R3: Before each walk, the engine writes zero to every entry, one entry per cycle, in linear order (row 0 column 0 first, columns fastest).
- R4: Each walk step reads an entry. One cycle later it compares the returned data against zero, and in that same cycle writes all ones to the same entry. mem_we and mem_re are never high together.
- R5: The first walk visits rows 0 up to ROWS-1. The second walk visits rows ROWS-1 down to 0. Columns run 0 to COLS-1 within each row.
- R6: With no nonzero read in either walk, busy is high for exactly 6·ROWS·COLS cycles. done then rises with fail low, and done stays high until the next start.
- R7: The first entry that reads nonzero during a detection walk becomes the victim, and its packed code appears on victim_code. The engine then zeroes the array and repeats the walk in the same row direction.
- R8: During the repeat walk, the victim is read before each write. When that read is nonzero, aggressor_code gives the entry written last, and done and fail both rise.
- R9: A packed code is row·8 + column. The column sits in bits 2:0, and the row sits from bit 3 upward.
- R10: The entry written last is derived as the previous entry of the walk. A column below zero wraps to column COLS-1 of row-1 in the ascending walk, or of row+1 in the descending walk.
- R11: aggressor_code is all ones when no write can be blamed. This happens when the victim already reads nonzero before the first write of the repeat walk, or when the repeat walk reaches the victim entry while the victim still reads zero. fail rises in both cases.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the engine is idle |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | High once a run has finished, until the next start |
| fail | output | 1 | High with done when a fault was found |
| victim_code | output | ROWS_W+3 | Packed location of the disturbed entry |
| aggressor_code | output | ROWS_W+3 | Packed location of the disturbing write, all ones if none |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_row | output | ROWS_W | Memory row address |
| mem_col | output | COLS_W | Memory column address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid one cycle after mem_re |

## Verification
The bench builds the engine with 16 rows, 4 columns and 8-bit data. This gives 64 entries and 7-bit codes, so a full fault-free run of 384 busy cycles can be checked exactly, along with the complete order of zero writes, reads and one writes. Sixteen rows leave room for couplings between different rows in both directions, for faults at the first and last entries of each walk, and for column-zero wrap cases in both walk directions. The bench's memory model also provides a same-row coupling that neither walk can see, a cell stuck at ones, and a coupling that fires only once, which covers both no-aggressor outcomes.

// File: rtl/mdft_pkg.sv
package mdft_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CLR  = 2'd1,
        ST_RD   = 2'd2,
        ST_CHK  = 2'd3
    } mdft_state_e;

    localparam int CODE_COL_BITS = 3;

endpackage

// File: rtl/mdft_step.sv
module mdft_step #(
    parameter int ROWS   = 16,
    parameter int COLS   = 4,
    parameter int ROWS_W = 4,
    parameter int COLS_W = 2
) (
    input  logic [ROWS_W-1:0] row,
    input  logic [COLS_W-1:0] col,
    input  logic              descend,
    output logic [ROWS_W-1:0] nxt_row,
    output logic [COLS_W-1:0] nxt_col,
    output logic [ROWS_W-1:0] prv_row,
    output logic [COLS_W-1:0] prv_col,
    output logic              is_first,
    output logic              is_last
);
    localparam logic [ROWS_W-1:0] ROW_TOP  = ROWS_W'(ROWS - 1);
    localparam logic [COLS_W-1:0] COL_TOP  = COLS_W'(COLS - 1);
    localparam logic [ROWS_W-1:0] ROW_ONE  = ROWS_W'(1);
    localparam logic [COLS_W-1:0] COL_ONE  = COLS_W'(1);

    logic [ROWS_W-1:0] row_start;
    logic [ROWS_W-1:0] row_end;
    logic [ROWS_W-1:0] row_fwd;
    logic [ROWS_W-1:0] row_back;

    always_comb begin
        row_start = descend ? ROW_TOP : '0;
        row_end   = descend ? '0 : ROW_TOP;
        row_fwd   = descend ? (row - ROW_ONE) : (row + ROW_ONE);
        row_back  = descend ? (row + ROW_ONE) : (row - ROW_ONE);

        is_first  = (col == '0) && (row == row_start);
        is_last   = (col == COL_TOP) && (row == row_end);

        if (col == COL_TOP) begin
            nxt_col = '0;
            nxt_row = row_fwd;
        end else begin
            nxt_col = col + COL_ONE;
            nxt_row = row;
        end

        if (col == '0) begin
            prv_col = COL_TOP;
            prv_row = row_back;
        end else begin
            prv_col = col - COL_ONE;
            prv_row = row;
        end
    end

endmodule

// File: rtl/mdft_pack.sv
module mdft_pack #(
    parameter int ROWS_W = 4,
    parameter int COLS_W = 2,
    parameter int CODE_W = ROWS_W + mdft_pkg::CODE_COL_BITS
) (
    input  logic [ROWS_W-1:0] row,
    input  logic [COLS_W-1:0] col,
    output logic [CODE_W-1:0] code
);
    localparam int PAD_W = mdft_pkg::CODE_COL_BITS - COLS_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign code = {row, {PAD_W{1'b0}}, col};
        end else begin : g_nopad
            assign code = {row, col};
        end
    endgenerate

endmodule

// File: rtl/mdft_engine.sv
module mdft_engine #(
    parameter int ROWS   = 16,
    parameter int COLS   = 4,
    parameter int DATA_W = 8,
    parameter int ROWS_W = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int COLS_W = (COLS > 1) ? $clog2(COLS) : 1,
    parameter int CODE_W = ROWS_W + mdft_pkg::CODE_COL_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [CODE_W-1:0] victim_code,
    output logic [CODE_W-1:0] aggressor_code,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ROWS_W-1:0] mem_row,
    output logic [COLS_W-1:0] mem_col,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import mdft_pkg::*;

    localparam logic [ROWS_W-1:0] ROW_TOP = ROWS_W'(ROWS - 1);
    localparam logic [CODE_W-1:0] NO_AGG  = '1;

    typedef struct packed {
        mdft_state_e       st;
        logic [ROWS_W-1:0] row;
        logic [COLS_W-1:0] col;
        logic [ROWS_W-1:0] vrow;
        logic [COLS_W-1:0] vcol;
        logic              dir;
        logic              loc;
        logic              busy;
        logic              done;
        logic              fail;
        logic [CODE_W-1:0] vcode;
        logic [CODE_W-1:0] acode;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        st:    ST_IDLE,
        row:   '0,
        col:   '0,
        vrow:  '0,
        vcol:  '0,
        dir:   1'b0,
        loc:   1'b0,
        busy:  1'b0,
        done:  1'b0,
        fail:  1'b0,
        vcode: '0,
        acode: '0
    };

    regs_t q, d;

    logic              step_desc;
    logic [ROWS_W-1:0] nxt_row, prv_row;
    logic [COLS_W-1:0] nxt_col, prv_col;
    logic              at_first, at_last;
    logic [CODE_W-1:0] cur_code, prv_code;
    logic              rd_nonzero;
    logic              at_victim;

    assign step_desc = (q.st == ST_CLR) ? 1'b0 : q.dir;

    mdft_step #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .ROWS_W (ROWS_W),
        .COLS_W (COLS_W)
    ) step_i (
        .row      (q.row),
        .col      (q.col),
        .descend  (step_desc),
        .nxt_row  (nxt_row),
        .nxt_col  (nxt_col),
        .prv_row  (prv_row),
        .prv_col  (prv_col),
        .is_first (at_first),
        .is_last  (at_last)
    );

    mdft_pack #(
        .ROWS_W (ROWS_W),
        .COLS_W (COLS_W),
        .CODE_W (CODE_W)
    ) pack_cur_i (
        .row  (q.row),
        .col  (q.col),
        .code (cur_code)
    );

    mdft_pack #(
        .ROWS_W (ROWS_W),
        .COLS_W (COLS_W),
        .CODE_W (CODE_W)
    ) pack_prv_i (
        .row  (prv_row),
        .col  (prv_col),
        .code (prv_code)
    );

    assign rd_nonzero = (mem_rdata != '0);
    assign at_victim  = (q.row == q.vrow) && (q.col == q.vcol);

    always_comb begin
        d         = q;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_wdata = '0;
        mem_row   = q.row;
        mem_col   = q.col;

        unique case (q.st)
            ST_IDLE: begin
                if (start) begin
                    d.st    = ST_CLR;
                    d.row   = '0;
                    d.col   = '0;
                    d.dir   = 1'b0;
                    d.loc   = 1'b0;
                    d.busy  = 1'b1;
                    d.done  = 1'b0;
                    d.fail  = 1'b0;
                    d.vcode = '0;
                    d.acode = '0;
                end
            end

            ST_CLR: begin
                mem_we    = 1'b1;
                mem_wdata = '0;
                if (at_last) begin
                    d.st  = ST_RD;
                    d.row = q.dir ? ROW_TOP : '0;
                    d.col = '0;
                end else begin
                    d.row = nxt_row;
                    d.col = nxt_col;
                end
            end

            ST_RD: begin
                mem_re = 1'b1;
                if (q.loc) begin
                    mem_row = q.vrow;
                    mem_col = q.vcol;
                end
                d.st = ST_CHK;
            end

            ST_CHK: begin
                if (!q.loc) begin
                    if (rd_nonzero) begin
                        d.vrow  = q.row;
                        d.vcol  = q.col;
                        d.vcode = cur_code;
                        d.loc   = 1'b1;
                        d.st    = ST_CLR;
                        d.row   = '0;
                        d.col   = '0;
                    end else begin
                        mem_we    = 1'b1;
                        mem_wdata = '1;
                        if (at_last) begin
                            if (!q.dir) begin
                                d.dir = 1'b1;
                                d.st  = ST_CLR;
                                d.row = '0;
                                d.col = '0;
                            end else begin
                                d.st   = ST_IDLE;
                                d.busy = 1'b0;
                                d.done = 1'b1;
                            end
                        end else begin
                            d.row = nxt_row;
                            d.col = nxt_col;
                            d.st  = ST_RD;
                        end
                    end
                end else begin
                    if (rd_nonzero || at_victim) begin
                        d.acode = (rd_nonzero && !at_first) ? prv_code : NO_AGG;
                        d.fail  = 1'b1;
                        d.done  = 1'b1;
                        d.busy  = 1'b0;
                        d.st    = ST_IDLE;
                    end else begin
                        mem_we    = 1'b1;
                        mem_wdata = '1;
                        d.row     = nxt_row;
                        d.col     = nxt_col;
                        d.st      = ST_RD;
                    end
                end
            end

            default: d = REGS_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= REGS_RESET;
        end else begin
            q <= d;
        end
    end

    assign busy           = q.busy;
    assign done           = q.done;
    assign fail           = q.fail;
    assign victim_code    = q.vcode;
    assign aggressor_code = q.acode;

    // R4: one port operation per cycle
    p_port_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    // R4: read data is consumed in the cycle after the request
    p_check_follows_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (q.st == ST_CHK));

    // R6: a run never ends without done
    p_busy_ends_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.done);

    // R8: fail only accompanies a finished run
    p_fail_implies_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        q.fail |-> q.done);

    // R7: the remembered victim stays fixed through localisation
    p_victim_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.loc && $past(q.loc) && q.busy) |-> ($stable(q.vrow) && $stable(q.vcol)));

    // R9: a reported aggressor carries a legal column field
    p_code_col_field_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.fail) && (q.acode != NO_AGG)) |-> (int'(q.acode[2:0]) < COLS));

    // R2: start during a run leaves the walk direction untouched
    p_start_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && start && q.dir) |=> (q.dir || !q.busy));

endmodule

// File: tb/mdft_engine_tb_top.sv
`timescale 1ns/1ps
module mdft_engine_tb_top;
    localparam int ROWS   = 16;
    localparam int COLS   = 4;
    localparam int DATA_W = 8;
    localparam int ROWS_W = 4;
    localparam int COLS_W = 2;
    localparam int CODE_W = 7;
    localparam int N      = ROWS * COLS;
    localparam int NV     = 10;

    // kind (0 none, 1 coupling, 2 stuck ones, 3 one-shot coupling),
    // aggr row, aggr col, victim row, victim col, exp fail, exp victim code, exp aggr code
    localparam int VEC [NV][8] = '{
        '{0,  0, 0,  0, 0, 0,   0,   0},  // R6 fault free
        '{1,  1, 2,  6, 1, 1,  49,  10},  // R7 R8 ascending detection
        '{1,  2, 3,  3, 1, 1,  25,  19},  // R10 ascending column wrap
        '{1,  5, 3,  4, 2, 1,  34,  43},  // R5 R10 descending detection and wrap
        '{1,  7, 3,  7, 1, 0,   0,   0},  // R5 same-row higher column: invisible
        '{2,  0, 0,  9, 2, 1,  74, 127},  // R11 stuck cell
        '{2,  0, 0,  0, 0, 1,   0, 127},  // R11 stuck at first entry
        '{3,  1, 0,  1, 1, 1,   9, 127},  // R11 fault does not recur
        '{1,  0, 0, 15, 3, 1, 123,   0},  // R9 victim at last entry
        '{1, 15, 0, 14, 0, 1, 112, 120}   // R8 descending, aggressor is first entry
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              busy, done, fail;
    logic [CODE_W-1:0] victim_code, aggressor_code;
    logic              mem_we, mem_re;
    logic [ROWS_W-1:0] mem_row;
    logic [COLS_W-1:0] mem_col;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;

    always #2.5 clk = ~clk;

    mdft_engine #(
        .ROWS   (ROWS),
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .start          (start),
        .busy           (busy),
        .done           (done),
        .fail           (fail),
        .victim_code    (victim_code),
        .aggressor_code (aggressor_code),
        .mem_we         (mem_we),
        .mem_re         (mem_re),
        .mem_row        (mem_row),
        .mem_col        (mem_col),
        .mem_wdata      (mem_wdata),
        .mem_rdata      (mem_rdata)
    );

    // behavioural memory with an injectable decoder fault
    logic [DATA_W-1:0] mem [N];
    int f_kind = 0;
    int f_ai   = 0;
    int f_vi   = 0;
    bit fired  = 1'b0;
    int acc_i;

    assign acc_i = int'(mem_row) * COLS + int'(mem_col);

    always @(posedge clk) begin
        if (mem_we) begin
            mem[acc_i] <= mem_wdata;
            if (f_kind == 1 && acc_i == f_ai)
                mem[f_vi] <= mem_wdata;
            if (f_kind == 3 && acc_i == f_ai && !fired && mem_wdata != '0) begin
                mem[f_vi] <= mem_wdata;
                fired <= 1'b1;
            end
        end
        if (mem_re)
            mem_rdata <= (f_kind == 2 && acc_i == f_vi) ? '1 : mem[acc_i];
    end

    // port activity monitor
    bit mon_on = 1'b0;
    int n_rd, n_w0, n_w1, clr_err, order_err, rw_err, last_rd;

    always @(negedge clk) begin
        if (mon_on) begin
            if (mem_re) begin
                n_rd++;
                last_rd = acc_i;
            end
            if (mem_we && mem_wdata == '0) begin
                if (acc_i != (n_w0 % N)) clr_err++;
                n_w0++;
            end
            if (mem_we && mem_wdata == '1) begin
                int exp_i;
                if (n_w1 < N) exp_i = n_w1;
                else exp_i = (ROWS - 1 - (n_w1 - N) / COLS) * COLS + (n_w1 - N) % COLS;
                if (acc_i != exp_i) order_err++;
                if (acc_i != last_rd) rw_err++;
                n_w1++;
            end
        end
    end

    int nchk = 0;
    int nfail = 0;
    int wd = 0;

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            nfail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            summary();
            $finish;
        end
    end

    task automatic clear_mon();
        n_rd = 0; n_w0 = 0; n_w1 = 0;
        clr_err = 0; order_err = 0; rw_err = 0; last_rd = -1;
    endtask

    // called at a negedge; returns busy cycle count
    task automatic run(input int extra_at, output int cyc, output int first_busy, output int first_done);
        int g;
        cyc = 0; g = 0;
        first_busy = 0; first_done = 1;
        start = 1'b1;
        do begin
            @(negedge clk);
            start = (g == extra_at);
            if (g == 0) begin
                first_busy = int'(busy);
                first_done = int'(done);
            end
            if (busy) cyc++;
            g++;
        end while (!done && g < 5000);
        start = 1'b0;
        if (g >= 5000) chk("run timeout", g, 0);
    endtask

    initial begin
        int cyc, fb, fd;

        // R1: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        chk("R1 port idle", int'(mem_we) + int'(mem_re), 0);
        chk("R1 codes", int'(victim_code) + int'(aggressor_code), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", int'(mem_we) + int'(mem_re) + int'(busy), 0);

        for (int v = 0; v < NV; v++) begin
            f_kind = VEC[v][0];
            f_ai   = VEC[v][1] * COLS + VEC[v][2];
            f_vi   = VEC[v][3] * COLS + VEC[v][4];
            fired  = 1'b0;
            clear_mon();
            mon_on = 1'b1;
            run(-1, cyc, fb, fd);
            mon_on = 1'b0;
            chk($sformatf("R6 busy after start vec%0d", v), fb, 1);
            chk($sformatf("R6 done cleared by start vec%0d", v), fd, 0);
            chk($sformatf("R8 fail vec%0d", v), int'(fail), VEC[v][5]);
            chk($sformatf("R7 R9 victim code vec%0d", v), int'(victim_code), VEC[v][6]);
            chk($sformatf("R8 R10 R11 aggressor code vec%0d", v), int'(aggressor_code), VEC[v][7]);
            if (VEC[v][0] == 0) begin
                chk("R6 busy cycles", cyc, 6 * N);
                chk("R3 zero writes", n_w0, 2 * N);
                chk("R3 clear order", clr_err, 0);
                chk("R4 reads", n_rd, 2 * N);
                chk("R4 write follows read of same entry", rw_err, 0);
                chk("R5 ones writes", n_w1, 2 * N);
                chk("R5 walk order", order_err, 0);
            end
            @(negedge clk);
        end

        // R6: done held while idle
        repeat (10) @(negedge clk);
        chk("R6 done held", int'(done), 1);
        chk("R6 busy low when idle", int'(busy), 0);

        // R2: extra start in the middle of a fault-free run
        f_kind = 0;
        run(100, cyc, fb, fd);
        chk("R2 busy cycles with extra start", cyc, 6 * N);
        chk("R2 result unchanged", int'(fail), 0);

        // R2: extra start during localisation keeps the result
        f_kind = 1; f_ai = 1 * COLS + 2; f_vi = 6 * COLS + 1;
        run(200, cyc, fb, fd);
        chk("R2 aggressor with extra start", int'(aggressor_code), 10);

        // R1: reset in mid-run
        f_kind = 0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset mid-run busy", int'(busy), 0);
        chk("R1 reset mid-run port", int'(mem_we) + int'(mem_re), 0);
        rst_n = 1'b1;
        @(negedge clk);

        summary();
        $finish;
    end

endmodule